// File: doc/BRIEF.md
# Static Test-Vector Apply and Compare Engine

This block tests a 24-pin device socket against a stored set of static vectors and reports a go/no-go verdict. For each vector it computes a drive word and places it on the pin drivers. Pins flagged as device outputs get the complement of their expected level, so an output that is open or floating reads back wrong. Pins flagged as device inputs get their stimulus value. After a programmable settle time it reads the socket back one 8-bit group at a time through a one-hot group select. It then compares the assembled 24-bit readback with the expected word. A per-bit care mask keeps supply pins and don't-care positions out of the comparison.

A host loads stimulus, output-pin flags, expected word and care mask into an internal vector array. It then sets the index of the last vector, the settle count and the stop-on-fail choice, and pulses `start`. The verdict comes back as a one-cycle `done` with `pass`. The first failing vector's index and its 24-bit mismatch pattern stay readable until the next run.

Top module: `vec_check_engine`

## Requirements
- R1: While vector k is applied, `pin_drive` equals (stim & ~outpin) | (~expect & outpin) of entry k. The word is updated when the vector begins and held until the vector's compare is over.
- R2: After a new drive word, `grp_sel` stays zero for `cfg_settle`+1 cycles. It then selects group 0 (pins 7:0, `grp_sel`=001), group 1 (pins 15:8, 010) and group 2 (pins 23:16, 100), one cycle each, never more than one bit at a time.
- R3: A vector fails when ((readback ^ expect) & care) is nonzero. A pin whose care bit is 0 never causes a failure.
- R4: `pass` is 1 in the `done` cycle exactly when no compared vector failed, and `pass` is never 1 outside `done`.
- R5: `fail_idx` and `fail_bits` hold the index and the masked mismatch pattern of the first failing vector of the latest run. Both read 0 after a run with no failure, and they do not change while the engine is idle.
- R6: With `cfg_stop`=1 the run ends right after the first failing vector's compare. With `cfg_stop`=0 all vectors 0..`cfg_last` are compared.
- R7: `done` rises exactly V·(`cfg_settle`+5) cycles after the clock edge that samples `start`, where V is the number of vectors compared. It lasts one cycle and `busy` is low on the next.
- R8: A `start` pulse while `busy` is 1 has no effect on the run in progress or on its length.
- R9: After reset, `busy`, `done`, `pass` and `grp_sel` are 0 and `pin_drive` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_we | input | 1 | Write one vector entry |
| ld_addr | input | 4 | Entry index for the write |
| ld_stim | input | 24 | Stimulus levels for input pins |
| ld_outpin | input | 24 | 1 marks a device output pin |
| ld_expect | input | 24 | Expected level of every pin |
| ld_care | input | 24 | 1 includes the pin in the compare |
| cfg_last | input | 4 | Index of the last vector of the run |
| cfg_settle | input | 8 | Settle cycles minus one before readback |
| cfg_stop | input | 1 | 1 ends the run at the first failure |
| start | input | 1 | Begin a run (ignored while busy) |
| pin_drive | output | 24 | Word driven onto the socket pins |
| grp_sel | output | 3 | One-hot readback group select |
| grp_data | input | 8 | Readback of the selected pin group |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run strobe |
| pass | output | 1 | Verdict, valid with done |
| fail_idx | output | 4 | Index of the first failing vector |
| fail_bits | output | 24 | Mismatch pattern of that vector |

## Verification
A wrong sequencer state shows at the ports within one vector period. A stuck or miscounted settle counter moves the first `grp_sel` pulse off cycle `cfg_settle`+1 and changes the `done` time. A skipped or repeated group breaks the 001/010/100 order seen one cycle later. A corrupted capture register or care path turns into a wrong `pass`, `fail_idx` or `fail_bits` at the next `done`. A failure record that is not cleared or is overwritten shows on the next passing run or on the second failing vector. A device model in the bench with open, stuck-high and stuck-low pins makes each of these faults visible.

// File: rtl/vce_pkg.sv
package vce_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_SETTLE = 3'd1,
    ST_READ   = 3'd2,
    ST_CMP    = 3'd3,
    ST_FIN    = 3'd4
  } vce_state_e;
endpackage

// File: rtl/vce_vec_mem.sv
module vce_vec_mem #(
  parameter int PIN_W = 24,
  parameter int DEPTH = 16,
  parameter int AW    = 4
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [PIN_W-1:0] wr_stim,
  input  logic [PIN_W-1:0] wr_outpin,
  input  logic [PIN_W-1:0] wr_expect,
  input  logic [PIN_W-1:0] wr_care,
  input  logic [AW-1:0]    rd_addr,
  output logic [PIN_W-1:0] rd_stim,
  output logic [PIN_W-1:0] rd_outpin,
  output logic [PIN_W-1:0] rd_expect,
  output logic [PIN_W-1:0] rd_care
);
  logic [PIN_W-1:0] stim_m   [DEPTH];
  logic [PIN_W-1:0] outpin_m [DEPTH];
  logic [PIN_W-1:0] expect_m [DEPTH];
  logic [PIN_W-1:0] care_m   [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      stim_m[wr_addr]   <= wr_stim;
      outpin_m[wr_addr] <= wr_outpin;
      expect_m[wr_addr] <= wr_expect;
      care_m[wr_addr]   <= wr_care;
    end
  end

  assign rd_stim   = stim_m[rd_addr];
  assign rd_outpin = outpin_m[rd_addr];
  assign rd_expect = expect_m[rd_addr];
  assign rd_care   = care_m[rd_addr];
endmodule

// File: rtl/vce_readback.sv
module vce_readback #(
  parameter int PIN_W = 24,
  parameter int GRP_W = 8,
  parameter int NGRP  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NGRP-1:0]  grp_sel,
  input  logic [GRP_W-1:0] grp_data,
  input  logic [PIN_W-1:0] exp_word,
  input  logic [PIN_W-1:0] care_word,
  output logic [PIN_W-1:0] mismatch
);
  logic [PIN_W-1:0] cap_word;

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    logic [GRP_W-1:0] cap_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cap_q <= '0;
      else if (grp_sel[g]) cap_q <= grp_data;
    end
    assign cap_word[g*GRP_W +: GRP_W] = cap_q;
  end

  assign mismatch = (cap_word ^ exp_word) & care_word;
endmodule

// File: rtl/vce_ctrl.sv
module vce_ctrl
  import vce_pkg::*;
#(
  parameter int PIN_W    = 24,
  parameter int NGRP     = 3,
  parameter int AW       = 4,
  parameter int SETTLE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [AW-1:0]       cfg_last,
  input  logic [SETTLE_W-1:0] cfg_settle,
  input  logic                cfg_stop,
  input  logic [PIN_W-1:0]    rd_stim,
  input  logic [PIN_W-1:0]    rd_outpin,
  input  logic [PIN_W-1:0]    rd_expect,
  input  logic [PIN_W-1:0]    rd_care,
  input  logic [PIN_W-1:0]    mismatch,
  output logic [AW-1:0]       rd_addr,
  output logic [PIN_W-1:0]    pin_drive,
  output logic [PIN_W-1:0]    exp_word,
  output logic [PIN_W-1:0]    care_word,
  output logic [NGRP-1:0]     grp_sel,
  output logic                busy,
  output logic                done,
  output logic                pass,
  output logic [AW-1:0]       fail_idx,
  output logic [PIN_W-1:0]    fail_bits
);
  localparam int GW = (NGRP > 1) ? $clog2(NGRP) : 1;
  localparam logic [GW-1:0] GLAST = GW'(NGRP - 1);

  vce_state_e          state_q, state_d;
  logic [AW-1:0]       idx_q, idx_d, last_q;
  logic [SETTLE_W-1:0] cnt_q, cnt_d, settle_q;
  logic [GW-1:0]       grp_q, grp_d;
  logic                stop_q, failed_q, failed_d;
  logic [AW-1:0]       fidx_d;
  logic [PIN_W-1:0]    fbits_d, drive_q, exp_q, care_q;
  logic                go, ld_vec, rec_en, hit;
  logic [PIN_W-1:0]    drive_nx;

  assign go       = (state_q == ST_IDLE) && start;
  assign hit      = |mismatch;
  assign drive_nx = (rd_stim & ~rd_outpin) | (~rd_expect & rd_outpin);

  always_comb begin
    state_d  = state_q;
    idx_d    = idx_q;
    cnt_d    = cnt_q;
    grp_d    = grp_q;
    failed_d = failed_q;
    fidx_d   = fail_idx;
    fbits_d  = fail_bits;
    ld_vec   = 1'b0;
    rec_en   = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start) begin
        idx_d    = '0;
        cnt_d    = cfg_settle;
        ld_vec   = 1'b1;
        rec_en   = 1'b1;
        failed_d = 1'b0;
        fidx_d   = '0;
        fbits_d  = '0;
        state_d  = ST_SETTLE;
      end
      ST_SETTLE: begin
        if (cnt_q == '0) begin
          grp_d   = '0;
          state_d = ST_READ;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      ST_READ: begin
        if (grp_q == GLAST) state_d = ST_CMP;
        else                grp_d   = grp_q + 1'b1;
      end
      ST_CMP: begin
        if (hit && !failed_q) begin
          rec_en   = 1'b1;
          failed_d = 1'b1;
          fidx_d   = idx_q;
          fbits_d  = mismatch;
        end
        if ((hit && stop_q) || (idx_q == last_q)) begin
          state_d = ST_FIN;
        end else begin
          idx_d   = idx_q + 1'b1;
          cnt_d   = settle_q;
          ld_vec  = 1'b1;
          state_d = ST_SETTLE;
        end
      end
      ST_FIN:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    for (int g = 0; g < NGRP; g++) begin
      grp_sel[g] = (state_q == ST_READ) && (grp_q == GW'(g));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      cnt_q   <= '0;
      grp_q   <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      cnt_q   <= cnt_d;
      grp_q   <= grp_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q   <= '0;
      settle_q <= '0;
      stop_q   <= 1'b0;
    end else if (go) begin
      last_q   <= cfg_last;
      settle_q <= cfg_settle;
      stop_q   <= cfg_stop;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drive_q <= '0;
      exp_q   <= '0;
      care_q  <= '0;
    end else if (ld_vec) begin
      drive_q <= drive_nx;
      exp_q   <= rd_expect;
      care_q  <= rd_care;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      failed_q  <= 1'b0;
      fail_idx  <= '0;
      fail_bits <= '0;
    end else if (rec_en) begin
      failed_q  <= failed_d;
      fail_idx  <= fidx_d;
      fail_bits <= fbits_d;
    end
  end

  assign rd_addr   = idx_d;
  assign pin_drive = drive_q;
  assign exp_word  = exp_q;
  assign care_word = care_q;
  assign busy      = (state_q != ST_IDLE);
  assign done      = (state_q == ST_FIN);
  assign pass      = done && !failed_q;
endmodule

// File: rtl/vec_check_engine.sv
module vec_check_engine #(
  parameter int PIN_W    = 24,
  parameter int GRP_W    = 8,
  parameter int DEPTH    = 16,
  parameter int SETTLE_W = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      ld_we,
  input  logic [$clog2(DEPTH)-1:0]  ld_addr,
  input  logic [PIN_W-1:0]          ld_stim,
  input  logic [PIN_W-1:0]          ld_outpin,
  input  logic [PIN_W-1:0]          ld_expect,
  input  logic [PIN_W-1:0]          ld_care,
  input  logic [$clog2(DEPTH)-1:0]  cfg_last,
  input  logic [SETTLE_W-1:0]       cfg_settle,
  input  logic                      cfg_stop,
  input  logic                      start,
  output logic [PIN_W-1:0]          pin_drive,
  output logic [PIN_W/GRP_W-1:0]    grp_sel,
  input  logic [GRP_W-1:0]          grp_data,
  output logic                      busy,
  output logic                      done,
  output logic                      pass,
  output logic [$clog2(DEPTH)-1:0]  fail_idx,
  output logic [PIN_W-1:0]          fail_bits
);
  localparam int NGRP = PIN_W / GRP_W;
  localparam int AW   = $clog2(DEPTH);

  logic [AW-1:0]    rd_addr;
  logic [PIN_W-1:0] rd_stim, rd_outpin, rd_expect, rd_care;
  logic [PIN_W-1:0] exp_word, care_word, mismatch;

  vce_vec_mem #(.PIN_W(PIN_W), .DEPTH(DEPTH), .AW(AW)) u_mem (
    .clk       (clk),
    .wr_en     (ld_we),
    .wr_addr   (ld_addr),
    .wr_stim   (ld_stim),
    .wr_outpin (ld_outpin),
    .wr_expect (ld_expect),
    .wr_care   (ld_care),
    .rd_addr   (rd_addr),
    .rd_stim   (rd_stim),
    .rd_outpin (rd_outpin),
    .rd_expect (rd_expect),
    .rd_care   (rd_care)
  );

  vce_readback #(.PIN_W(PIN_W), .GRP_W(GRP_W), .NGRP(NGRP)) u_rdbk (
    .clk       (clk),
    .rst_n     (rst_n),
    .grp_sel   (grp_sel),
    .grp_data  (grp_data),
    .exp_word  (exp_word),
    .care_word (care_word),
    .mismatch  (mismatch)
  );

  vce_ctrl #(.PIN_W(PIN_W), .NGRP(NGRP), .AW(AW), .SETTLE_W(SETTLE_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .cfg_last   (cfg_last),
    .cfg_settle (cfg_settle),
    .cfg_stop   (cfg_stop),
    .rd_stim    (rd_stim),
    .rd_outpin  (rd_outpin),
    .rd_expect  (rd_expect),
    .rd_care    (rd_care),
    .mismatch   (mismatch),
    .rd_addr    (rd_addr),
    .pin_drive  (pin_drive),
    .exp_word   (exp_word),
    .care_word  (care_word),
    .grp_sel    (grp_sel),
    .busy       (busy),
    .done       (done),
    .pass       (pass),
    .fail_idx   (fail_idx),
    .fail_bits  (fail_bits)
  );
endmodule

// File: rtl/vce_chk.sv
module vce_chk #(
  parameter int PIN_W = 24,
  parameter int NGRP  = 3,
  parameter int AW    = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [PIN_W-1:0] pin_drive,
  input logic [NGRP-1:0]  grp_sel,
  input logic             busy,
  input logic             done,
  input logic             pass,
  input logic [AW-1:0]    fail_idx,
  input logic [PIN_W-1:0] fail_bits
);
  // R2
  grp_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grp_sel));

  for (genvar g = 1; g < NGRP; g++) begin : g_ord
    // R2
    grp_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(grp_sel[g]) |-> $past(grp_sel[g-1]));
  end

  // R1
  drive_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|grp_sel) |-> $stable(pin_drive));

  // R4
  pass_in_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pass |-> done);

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));

  // R8
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);

  // R5
  record_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(fail_idx) && $stable(fail_bits)));
endmodule

bind vec_check_engine vce_chk #(.PIN_W(PIN_W), .NGRP(NGRP), .AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .pin_drive (pin_drive),
  .grp_sel   (grp_sel),
  .busy      (busy),
  .done      (done),
  .pass      (pass),
  .fail_idx  (fail_idx),
  .fail_bits (fail_bits)
);

// File: tb/test_vec_check_engine.sv
module test_vec_check_engine;
  localparam int CLK_PERIOD = 10;
  localparam logic [23:0] OUTPINS = 24'h000F00;
  localparam logic [23:0] CARE    = 24'h7FFFFF;

  logic        clk, rst_n, ld_we, cfg_stop, start;
  logic [3:0]  ld_addr, cfg_last, fail_idx;
  logic [23:0] ld_stim, ld_outpin, ld_expect, ld_care, pin_drive, fail_bits;
  logic [7:0]  cfg_settle, grp_data;
  logic [2:0]  grp_sel;
  logic        busy, done, pass;
  logic [23:0] open_m, st1_m, st0_m, good, rb;
  int          errors, checks;

  vec_check_engine i_vec_check_engine (
    .clk(clk), .rst_n(rst_n), .ld_we(ld_we), .ld_addr(ld_addr),
    .ld_stim(ld_stim), .ld_outpin(ld_outpin), .ld_expect(ld_expect),
    .ld_care(ld_care), .cfg_last(cfg_last), .cfg_settle(cfg_settle),
    .cfg_stop(cfg_stop), .start(start), .pin_drive(pin_drive),
    .grp_sel(grp_sel), .grp_data(grp_data), .busy(busy), .done(done),
    .pass(pass), .fail_idx(fail_idx), .fail_bits(fail_bits)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // device in the socket: pins 3:0 = a, 7:4 = b, 11:8 = a^b, 23 = supply
  always_comb begin
    good       = pin_drive;
    good[11:8] = pin_drive[3:0] ^ pin_drive[7:4];
    good[23]   = 1'b1;
    rb = ((good & ~open_m) | (pin_drive & open_m) | st1_m) & ~st0_m;
    grp_data = '0;
    for (int g = 0; g < 3; g++) if (grp_sel[g]) grp_data = rb[g*8 +: 8];
  end

  function automatic logic [23:0] f_stim(int k);
    logic [3:0] a, b;
    a = 4'(k); b = 4'(3*k + 5);
    return {16'h0, b, a};
  endfunction
  function automatic logic [23:0] f_exp(int k);
    logic [23:0] s;
    s = f_stim(k);
    return {12'h0, s[3:0] ^ s[7:4], s[7:0]};
  endfunction
  function automatic logic [23:0] f_drive(int k);
    return (f_stim(k) & ~OUTPINS) | (~f_exp(k) & OUTPINS);
  endfunction
  function automatic logic [23:0] f_mis(int k, logic [23:0] op, logic [23:0] s1, logic [23:0] s0);
    logic [23:0] d, gd, r;
    d = f_drive(k);
    gd = d; gd[11:8] = d[3:0] ^ d[7:4]; gd[23] = 1'b1;
    r = ((gd & ~op) | (d & op) | s1) & ~s0;
    return (r ^ f_exp(k)) & CARE;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  task automatic run_case(input int nvec, input int settle, input bit stop,
                          input logic [23:0] op, input logic [23:0] s1,
                          input logic [23:0] s0, input bit poke);
    int first, vproc, expc, e;
    logic [23:0] fb, m;
    logic [2:0] g0, g1, g2;
    logic [23:0] d0;
    int rise;
    first = -1; fb = '0; rise = -1; g0 = '0; g1 = '0; g2 = '0; d0 = '0;
    for (int k = 0; k < nvec; k++) begin
      m = f_mis(k, op, s1, s0);
      if (m != 0 && first < 0) begin first = k; fb = m; end
    end
    vproc = (stop && first >= 0) ? first + 1 : nvec;
    expc  = vproc * (settle + 5);
    @(negedge clk);
    open_m = op; st1_m = s1; st0_m = s0;
    cfg_last = 4'(nvec - 1); cfg_settle = 8'(settle); cfg_stop = stop;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    e = 0;
    while (!done && e < 5000) begin
      if (grp_sel == 3'b001 && rise < 0) begin rise = e; g0 = grp_sel; d0 = pin_drive; end
      if (rise >= 0 && e == rise + 1) g1 = grp_sel;
      if (rise >= 0 && e == rise + 2) g2 = grp_sel;
      if (poke && e == 2) start = 1'b1;
      if (poke && e == 3) start = 1'b0;
      @(negedge clk);
      e++;
    end
    start = 1'b0;
    chk(e < 5000, "R7", "watchdog on done", 32'(e), 32'(expc));
    chk(e == expc, stop ? "R6" : "R7", "cycles to done", 32'(e), 32'(expc));
    if (poke) chk(e == expc, "R8", "start while busy changed run", 32'(e), 32'(expc));
    chk(rise == settle + 1, "R2", "first group select cycle", 32'(rise), 32'(settle + 1));
    chk(g0 == 3'b001 && g1 == 3'b010 && g2 == 3'b100, "R2", "group order",
        {8'(g0), 8'(g1), 8'(g2)}, 32'h010204);
    chk(d0 == f_drive(0), "R1", "drive word vector 0", 32'(d0), 32'(f_drive(0)));
    chk(pass == (first < 0), "R4", "verdict", 32'(pass), 32'(first < 0));
    chk(fail_idx == 4'((first < 0) ? 0 : first), "R5", "fail index",
        32'(fail_idx), 32'((first < 0) ? 0 : first));
    chk(fail_bits == fb, "R3", "mismatch pattern", 32'(fail_bits), 32'(fb));
    @(negedge clk);
    chk(!done && !busy, "R7", "done one cycle", {30'h0, done, busy}, 32'h0);
    repeat (3) @(negedge clk);
    chk(fail_bits == fb, "R5", "record held idle", 32'(fail_bits), 32'(fb));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    errors = 0; checks = 0;
    rst_n = 1'b0; ld_we = 1'b0; ld_addr = '0; ld_stim = '0; ld_outpin = '0;
    ld_expect = '0; ld_care = '0; cfg_last = '0; cfg_settle = '0;
    cfg_stop = 1'b0; start = 1'b0; open_m = '0; st1_m = '0; st0_m = '0;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(!busy && !done && !pass && grp_sel == 0 && pin_drive == 0, "R9", "reset state",
        {8'(busy), 8'(done), 8'(grp_sel), 8'(pin_drive != 0)}, 32'h0);
    rst_n = 1'b1;
    for (int k = 0; k < 16; k++) begin
      @(negedge clk);
      ld_we = 1'b1; ld_addr = 4'(k); ld_stim = f_stim(k);
      ld_outpin = OUTPINS; ld_expect = f_exp(k); ld_care = CARE;
    end
    @(negedge clk);
    ld_we = 1'b0;
    run_case(8, 3, 1'b0, '0, '0, '0, 1'b0);           // good device
    run_case(16, 0, 1'b0, '0, '0, '0, 1'b0);          // full depth, zero settle
    run_case(8, 2, 1'b1, 24'h000200, '0, '0, 1'b0);   // open output pin 9, R6 stop
    run_case(8, 1, 1'b0, '0, 24'h000400, '0, 1'b0);   // stuck-high output, continue
    run_case(8, 1, 1'b1, '0, 24'h000400, '0, 1'b0);   // same, stop
    run_case(10, 0, 1'b1, '0, '0, 24'h000004, 1'b0);  // stuck-low input pin 2
    run_case(6, 2, 1'b0, '0, '0, 24'h800000, 1'b0);   // R3 supply pin outside care
    run_case(5, 4, 1'b0, '0, '0, '0, 1'b1);           // R8 start poked mid-run
    for (int s = 0; s < 6; s++) run_case(4, s, 1'b0, '0, '0, '0, 1'b0);
    for (int s = 0; s < 4; s++) run_case(12, s, 1'b0, 24'h000100, '0, '0, 1'b0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule